// File: doc/BRIEF.md
# Virtual Interrupt List Register Slot

One entry of the list used by a virtual CPU interrupt interface. Host software fills the entry with a virtual interrupt ID, a two-bit state and, optionally, a hardware-link flag with the ID of a physical interrupt. The guest then reads the entry through an acknowledge port and retires it through a deactivate port.

An acknowledge of a pending entry hands the virtual ID to the guest and marks the entry active. A deactivate that names the held ID clears the active part. When the entry is hardware-linked, that deactivation also sends a one-cycle request carrying the physical ID to the physical distributor, so that the physical interrupt is retired together with the virtual one.

A linked entry may be pending or active, but never both. The slot refuses a host write that asks for that combination, keeps its old contents and flags the error.

Top module: `vlr_slot`

## Requirements
- R1: After reset the state is Invalid (code 00), the link flag is clear, and the error and physical-deactivate outputs are low.
- R2: A host write that is not rejected loads the virtual ID, state, link flag and physical ID, all visible on the outputs after the next clock edge. State bit 0 means pending and bit 1 means active: 00 Invalid, 01 Pending, 10 Active, 11 Pending+Active.
- R3: A host write with the link flag set and state 11 is rejected. Contents stay as they were, and host_err_o is high for exactly the cycle after the write.
- R4: A guest acknowledge while the state is 01 returns the held virtual ID on ack_id_o in the same cycle, and the state becomes 10.
- R5: A guest acknowledge while the state is 11 returns the virtual ID, and the state becomes 10.
- R6: A guest acknowledge while the pending bit is clear returns the all-ones ID and leaves the state unchanged.
- R7: A deactivate whose ID equals the held virtual ID clears the active bit: 10 becomes 00 and 11 becomes 01.
- R8: A deactivate with a different ID, or one that arrives while the active bit is clear, changes nothing.
- R9: A successful deactivate of a linked entry raises phys_deact_o for exactly one cycle, on the cycle after, with the held physical ID on phys_deact_id_o. An unlinked entry never raises it.
- R10: A host write, accepted or rejected, takes priority over any guest operation in the same cycle. That guest operation has no effect, and an acknowledge in that cycle returns the all-ones ID.
- R11: When an acknowledge and a deactivate arrive in the same cycle, the acknowledge is performed and the deactivate is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host write strobe |
| host_vid_i | input | VID_W | Virtual ID to load |
| host_state_i | input | 2 | State to load |
| host_hw_i | input | 1 | Hardware-link flag to load |
| host_pid_i | input | PID_W | Linked physical ID to load |
| host_err_o | output | 1 | Rejected-write flag |
| state_o | output | 2 | Current state |
| vid_o | output | VID_W | Held virtual ID |
| hw_o | output | 1 | Held link flag |
| pid_o | output | PID_W | Held physical ID |
| guest_ack_i | input | 1 | Guest acknowledge read |
| ack_id_o | output | VID_W | ID returned for the acknowledge |
| guest_dir_i | input | 1 | Guest deactivate request |
| guest_dir_id_i | input | VID_W | ID named by the deactivate |
| phys_deact_o | output | 1 | Physical deactivate strobe |
| phys_deact_id_o | output | PID_W | Physical ID for the strobe |

## Verification
The bench crosses all four states with both link settings and with every guest operation: acknowledge, matching and mismatching deactivate, and acknowledge together with deactivate. A design that let the illegal linked 11 write through would present a double-state linked entry, and one that ignored the ID compare would retire an entry the guest never named. A missing or stretched physical strobe would leave the physical interrupt active forever or retire it twice. The bench also drives a host write over a guest acknowledge to catch a design that lets the guest consume the entry the host is replacing.

// File: rtl/vlr_pkg.sv
package vlr_pkg;
  // bit0 = pending, bit1 = active
  typedef enum logic [1:0] {
    ST_INV  = 2'b00,
    ST_PEND = 2'b01,
    ST_ACT  = 2'b10,
    ST_PA   = 2'b11
  } lr_state_e;
endpackage

// File: rtl/vlr_wr_gate.sv
module vlr_wr_gate
  import vlr_pkg::*;
(
  input  logic       we_i,
  input  logic [1:0] state_i,
  input  logic       hw_i,
  output logic       accept_o,
  output logic       reject_o
);
  always_comb begin
    reject_o = we_i && hw_i && (state_i == ST_PA);
    accept_o = we_i && !reject_o;
  end
endmodule

// File: rtl/vlr_guest_next.sv
module vlr_guest_next
  import vlr_pkg::*;
#(
  parameter int VID_W = 10
) (
  input  logic [1:0]       cur_state_i,
  input  logic [VID_W-1:0] cur_vid_i,
  input  logic             cur_hw_i,
  input  logic             host_busy_i,
  input  logic             ack_i,
  input  logic             dir_i,
  input  logic [VID_W-1:0] dir_id_i,
  output logic [1:0]       nxt_state_o,
  output logic [VID_W-1:0] ack_id_o,
  output logic             link_deact_o
);
  localparam logic [VID_W-1:0] SpurId = '1;

  logic ack_ok, dir_ok;

  always_comb begin
    ack_ok = ack_i && !host_busy_i;
    dir_ok = dir_i && !host_busy_i && !ack_i && cur_state_i[1] && (dir_id_i == cur_vid_i);
    nxt_state_o = cur_state_i;
    if (ack_ok && cur_state_i[0]) nxt_state_o = ST_ACT;
    else if (dir_ok)              nxt_state_o = {1'b0, cur_state_i[0]};
    ack_id_o     = (ack_ok && cur_state_i[0]) ? cur_vid_i : SpurId;
    link_deact_o = dir_ok && cur_hw_i;
  end
endmodule

// File: rtl/vlr_slot.sv
module vlr_slot
  import vlr_pkg::*;
#(
  parameter int VID_W = 10,
  parameter int PID_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             host_we_i,
  input  logic [VID_W-1:0] host_vid_i,
  input  logic [1:0]       host_state_i,
  input  logic             host_hw_i,
  input  logic [PID_W-1:0] host_pid_i,
  output logic             host_err_o,
  output logic [1:0]       state_o,
  output logic [VID_W-1:0] vid_o,
  output logic             hw_o,
  output logic [PID_W-1:0] pid_o,
  input  logic             guest_ack_i,
  output logic [VID_W-1:0] ack_id_o,
  input  logic             guest_dir_i,
  input  logic [VID_W-1:0] guest_dir_id_i,
  output logic             phys_deact_o,
  output logic [PID_W-1:0] phys_deact_id_o
);
  logic [1:0]       state_q, nxt_state;
  logic [VID_W-1:0] vid_q;
  logic [PID_W-1:0] pid_q, pdeact_id_q;
  logic             hw_q, err_q, pdeact_q;
  logic             wr_accept, wr_reject, link_deact;

  vlr_wr_gate u_wr_gate (
    .we_i     (host_we_i),
    .state_i  (host_state_i),
    .hw_i     (host_hw_i),
    .accept_o (wr_accept),
    .reject_o (wr_reject)
  );

  vlr_guest_next #(.VID_W(VID_W)) u_guest_next (
    .cur_state_i  (state_q),
    .cur_vid_i    (vid_q),
    .cur_hw_i     (hw_q),
    .host_busy_i  (host_we_i),
    .ack_i        (guest_ack_i),
    .dir_i        (guest_dir_i),
    .dir_id_i     (guest_dir_id_i),
    .nxt_state_o  (nxt_state),
    .ack_id_o     (ack_id_o),
    .link_deact_o (link_deact)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_INV;
      vid_q   <= '0;
      pid_q   <= '0;
      hw_q    <= 1'b0;
    end else if (wr_accept) begin
      state_q <= host_state_i;
      vid_q   <= host_vid_i;
      pid_q   <= host_pid_i;
      hw_q    <= host_hw_i;
    end else begin
      state_q <= nxt_state;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q       <= 1'b0;
      pdeact_q    <= 1'b0;
      pdeact_id_q <= '0;
    end else begin
      err_q    <= wr_reject;
      pdeact_q <= link_deact;
      if (link_deact) pdeact_id_q <= pid_q;
    end
  end

  assign host_err_o      = err_q;
  assign state_o         = state_q;
  assign vid_o           = vid_q;
  assign hw_o            = hw_q;
  assign pid_o           = pid_q;
  assign phys_deact_o    = pdeact_q;
  assign phys_deact_id_o = pdeact_id_q;
endmodule

// File: rtl/vlr_slot_chk.sv
module vlr_slot_chk #(
  parameter int VID_W = 10,
  parameter int PID_W = 13
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             host_we_i,
  input logic [VID_W-1:0] host_vid_i,
  input logic [1:0]       host_state_i,
  input logic             host_hw_i,
  input logic             host_err_o,
  input logic [1:0]       state_o,
  input logic [VID_W-1:0] vid_o,
  input logic             hw_o,
  input logic             guest_ack_i,
  input logic [VID_W-1:0] ack_id_o,
  input logic             phys_deact_o
);
  logic bad_wr;
  assign bad_wr = host_we_i && host_hw_i && (host_state_i == 2'b11);

  assert_reject_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_wr |=> host_err_o && (state_o == $past(state_o)) && (vid_o == $past(vid_o)));

  assert_no_linked_pa_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_o |-> (state_o != 2'b11));

  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_we_i && !bad_wr) |=> (vid_o == $past(host_vid_i)) && (state_o == $past(host_state_i)));

  assert_ack_id_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (guest_ack_i && !host_we_i && state_o[0]) |-> (ack_id_o == vid_o));

  assert_ack_move_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (guest_ack_i && !host_we_i && state_o[0]) |=> (state_o == 2'b10));

  assert_spurious_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (guest_ack_i && !host_we_i && !state_o[0]) |=> (state_o == $past(state_o)));

  assert_strobe_src_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phys_deact_o |-> ($past(state_o) == 2'b10) && $past(hw_o) && (state_o == 2'b00));

  assert_strobe_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phys_deact_o |=> !phys_deact_o);
endmodule

bind vlr_slot vlr_slot_chk #(.VID_W(VID_W), .PID_W(PID_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .host_we_i    (host_we_i),
  .host_vid_i   (host_vid_i),
  .host_state_i (host_state_i),
  .host_hw_i    (host_hw_i),
  .host_err_o   (host_err_o),
  .state_o      (state_o),
  .vid_o        (vid_o),
  .hw_o         (hw_o),
  .guest_ack_i  (guest_ack_i),
  .ack_id_o     (ack_id_o),
  .phys_deact_o (phys_deact_o)
);

// File: tb/vlr_slot_tb.sv
`timescale 1ns/1ps
module vlr_slot_tb;
  localparam int VID_W = 10;
  localparam int PID_W = 13;
  localparam int SPUR  = (1 << VID_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             host_we = 1'b0;
  logic [VID_W-1:0] host_vid = '0;
  logic [1:0]       host_state = '0;
  logic             host_hw = 1'b0;
  logic [PID_W-1:0] host_pid = '0;
  logic             host_err;
  logic [1:0]       state;
  logic [VID_W-1:0] vid;
  logic             hw;
  logic [PID_W-1:0] pid;
  logic             ack = 1'b0;
  logic [VID_W-1:0] ack_id;
  logic             dir = 1'b0;
  logic [VID_W-1:0] dir_id = '0;
  logic             pdeact;
  logic [PID_W-1:0] pdeact_id;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  vlr_slot #(.VID_W(VID_W), .PID_W(PID_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .host_we_i(host_we), .host_vid_i(host_vid), .host_state_i(host_state),
    .host_hw_i(host_hw), .host_pid_i(host_pid), .host_err_o(host_err),
    .state_o(state), .vid_o(vid), .hw_o(hw), .pid_o(pid),
    .guest_ack_i(ack), .ack_id_o(ack_id),
    .guest_dir_i(dir), .guest_dir_id_i(dir_id),
    .phys_deact_o(pdeact), .phys_deact_id_o(pdeact_id)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input int v, input int s, input int h, input int p);
    @(negedge clk);
    host_we = 1'b1; host_vid = v[VID_W-1:0]; host_state = s[1:0];
    host_hw = h[0]; host_pid = p[PID_W-1:0];
    @(posedge clk);
    @(negedge clk);
    host_we = 1'b0;
    #1;
  endtask

  // op: 0 ack, 1 deactivate matching, 2 deactivate mismatching, 3 ack+deactivate
  task automatic guest_op(input int op, input int id, output int got_id);
    @(negedge clk);
    ack    = (op == 0 || op == 3);
    dir    = (op != 0);
    dir_id = (op == 2) ? (id[VID_W-1:0] ^ 1) : id[VID_W-1:0];
    #1;
    got_id = int'(ack_id);
    @(posedge clk);
    @(negedge clk);
    ack = 1'b0; dir = 1'b0;
    #1;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int got;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 state", int'(state), 0);
    chk("R1 hw", int'(hw), 0);
    chk("R1 err", int'(host_err), 0);
    chk("R1 pdeact", int'(pdeact), 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int s = 0; s < 4; s++) begin
      for (int h = 0; h < 2; h++) begin
        for (int op = 0; op < 4; op++) begin
          int ill, st_e, vid_e, hw_e, pid_e, nst, strobe, id_e;
          host_wr(1, 0, 0, 0);
          host_wr(5 + s, s, h, 9 + op);
          ill   = (h == 1 && s == 3) ? 1 : 0;
          st_e  = ill ? 0 : s;
          vid_e = ill ? 1 : 5 + s;
          hw_e  = ill ? 0 : h;
          pid_e = ill ? 0 : 9 + op;
          chk(ill ? "R3 err" : "R2 err", int'(host_err), ill);
          chk(ill ? "R3 state kept" : "R2 state", int'(state), st_e);
          chk(ill ? "R3 vid kept" : "R2 vid", int'(vid), vid_e);
          chk(ill ? "R3 hw kept" : "R2 hw", int'(hw), hw_e);
          chk(ill ? "R3 pid kept" : "R2 pid", int'(pid), pid_e);
          guest_op(op, vid_e, got);
          chk("R3 err one cycle", int'(host_err), 0);
          strobe = 0;
          nst = st_e;
          id_e = SPUR;
          if (op == 0 || op == 3) begin
            id_e = (st_e % 2 == 1) ? vid_e : SPUR;
            nst  = (st_e % 2 == 1) ? 2 : st_e;
            chk(st_e == 1 ? "R4 ack id" : st_e == 3 ? "R5 ack id" : "R6 spurious id", got, id_e);
            chk(st_e == 1 ? "R4 ack state" : st_e == 3 ? "R5 ack state" : "R6 state kept", int'(state), nst);
            if (op == 3) chk("R11 no strobe", int'(pdeact), 0);
          end else if (op == 1) begin
            if (st_e >= 2) begin
              nst = st_e % 2;
              strobe = hw_e;
            end
            chk(st_e >= 2 ? "R7 deact state" : "R8 inactive ignored", int'(state), nst);
          end else begin
            chk("R8 mismatch ignored", int'(state), st_e);
          end
          chk("R9 strobe", int'(pdeact), strobe);
          if (strobe == 1) chk("R9 strobe id", int'(pdeact_id), pid_e);
          @(negedge clk);
          #1;
          chk("R9 strobe one cycle", int'(pdeact), 0);
        end
      end
    end

    // R10: host write wins over a guest acknowledge in the same cycle
    host_wr(3, 1, 0, 4);
    @(negedge clk);
    host_we = 1'b1; host_vid = 7; host_state = 2'b10; host_hw = 1'b1; host_pid = 21;
    ack = 1'b1;
    #1;
    chk("R10 ack spurious", int'(ack_id), SPUR);
    @(posedge clk);
    @(negedge clk);
    host_we = 1'b0; ack = 1'b0;
    #1;
    chk("R10 state from host", int'(state), 2);
    chk("R10 vid from host", int'(vid), 7);

    // R10: rejected write still blocks a matching deactivate
    @(negedge clk);
    host_we = 1'b1; host_vid = 9; host_state = 2'b11; host_hw = 1'b1; host_pid = 5;
    dir = 1'b1; dir_id = 7;
    @(posedge clk);
    @(negedge clk);
    host_we = 1'b0; dir = 1'b0;
    #1;
    chk("R10 rejected write err", int'(host_err), 1);
    chk("R10 deact blocked state", int'(state), 2);
    chk("R10 deact blocked strobe", int'(pdeact), 0);

    // R11: ack and deactivate together on an Active entry: ack wins, nothing pending
    guest_op(3, 7, got);
    chk("R11 spurious id", got, SPUR);
    chk("R11 state kept", int'(state), 2);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule